// File: doc/BRIEF.md
# Knock-Sequence Unlocked Timing Register

This block sits on the device side of an 8-bit I/O bus, behind a legacy ATA task-file address window. It holds the plain sector-count, sector-number, cylinder-low and cylinder-high registers. It also holds a hidden register that carries a PIO timing code for each attached drive. The hidden register is reached only after the host issues one exact pattern of ordinary task-file reads and writes, called the knock.

While the block is locked, bit 7 of the sector-count port reads back as 1. Once the knock completes, the bit reads back as 0, and the sector-number port becomes a window onto the pending timing codes. The host writes the codes there and then writes sector-count with bit 0 set to commit them to the drive outputs. A read of cylinder-high closes the window again.

A build parameter selects a second silicon variant. That variant never unlocks, and its sector-count port always reads 0x00, so host software can tell the two variants apart.

Top module: `knock_timing_unlock`

## Requirements
- R1: After synchronous reset the block is locked, every drive code is 0 and every decoded drive mode is 0, and the sector-count, sector-number, cylinder-low and cylinder-high registers hold 0x00.
- R2: The knock works as follows. First comes a read of cylinder-high (offset 5). Next comes a write of sector-count (offset 2) with bit 7 set. Then come one read of sector-count, two reads of alternate status (control window, offset 6) and two reads of sector-count. After this the block is unlocked. The read of sector-count that follows returns bit 7 as 0 and bits 6:0 as last written.
- R3: While the block is locked, a read of sector-count returns the last written value with bit 7 forced to 1. Sector-number, cylinder-low and cylinder-high read back their last written values. Alternate status reads the ALT_STATUS parameter (default 0x50). Unwatched offsets read 0x00.
- R4: Any access that does not continue the knock sends the knock back to its start. An access to a port outside the watched set, an access out of order, or a sector-count write with bit 7 clear all count as breaking the knock. A cylinder-high read always begins a fresh attempt, and reads of sector-count between that read and the bit-7 write are tolerated. After a broken knock the block stays locked, and a complete knock issued right afterwards unlocks it.
- R5: While the block is unlocked, offset 3 reads and writes the pending timing register. Drive 0 is bits 2:0 and drive 1 is bits 5:3, and the upper bits read as 0.
- R6: A sector-count write with bit 0 set while unlocked copies the pending timing to the drive code outputs on that clock edge. A sector-count write with bit 0 clear leaves the drive codes unchanged. While the block is locked, no write changes the drive codes.
- R7: A read of cylinder-high relocks the block. Afterwards sector-count bit 7 reads 1 again, and offset 3 reads the plain sector-number value, which writes to the timing register did not alter.
- R8: Each drive's 3-bit code decodes to a 2-bit mode as follows: code 0 gives mode 0, code 4 gives mode 1, code 7 gives mode 2, and any other code gives mode 0.
- R9: With HAS_UNLOCK = 0, sector-count always reads 0x00 (so a write of 0x55 reads back 0x00), and no knock ever unlocks the block or changes the drive codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ioAddr | input | 3 | Register offset inside the selected window |
| ctlSel | input | 1 | 1 selects the control window, 0 the command window |
| ioRd | input | 1 | Single-cycle read strobe |
| ioWr | input | 1 | Single-cycle write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register, valid while ioRd is high |
| driveCode | output | 6 | Committed timing code, 3 bits per drive |
| driveMode | output | 4 | Decoded PIO mode, 2 bits per drive |

## Verification
The hardest situation to reach is a knock that breaks partway through and is then retried at once. Whether the retry succeeds depends on where the knock state machine was left, and nothing at the ports shows that state. The stimulus therefore runs two broken knocks in a row: one with an out-of-order cylinder-low read after the alternate-status reads, and one whose sector-count write has bit 7 clear. Each broken knock is checked by the forced bit 7 on the next sector-count read. A full knock follows with no idle gap, including the tolerated read-modify-write read of sector-count. A second instance built as the non-unlocking variant sees the same bus traffic and must never open.

// File: rtl/knock_pkg.sv
`timescale 1ns/1ps
package knock_pkg;
  localparam logic [2:0] P_SCNT  = 3'd2;
  localparam logic [2:0] P_SNUM  = 3'd3;
  localparam logic [2:0] P_CLOW  = 3'd4;
  localparam logic [2:0] P_CHIGH = 3'd5;
  localparam logic [2:0] P_ALT   = 3'd6;
  localparam int MODE_W = 2;

  typedef enum logic [2:0] {
    K_IDLE, K_CH, K_SCW, K_SCR, K_AS1, K_AS2, K_SC3
  } knockState_t;

  typedef struct packed {
    logic open;
    logic timWr;
    logic commit;
  } ctlStrobe_t;
endpackage

// File: rtl/knock_ctrl.sv
`timescale 1ns/1ps
module knock_ctrl
  import knock_pkg::*;
#(
  parameter bit HAS_UNLOCK = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] ioAddr,
  input  logic       ctlSel,
  input  logic       ioRd,
  input  logic       ioWr,
  input  logic       knockBit,
  input  logic       commitBit,
  output ctlStrobe_t strobe
);
  knockState_t state, stateNext;
  logic openQ;

  logic cmdWin, chRd, scRd, scWr, altRd, anyAcc;
  assign cmdWin = !ctlSel;
  assign chRd   = ioRd && cmdWin && (ioAddr == P_CHIGH);
  assign scRd   = ioRd && cmdWin && (ioAddr == P_SCNT);
  assign scWr   = ioWr && cmdWin && (ioAddr == P_SCNT);
  assign altRd  = ioRd && ctlSel && (ioAddr == P_ALT);
  assign anyAcc = ioRd || ioWr;

  // Knock progress: a cylinder-high read always starts over; anything else
  // that is not the expected next step returns to idle.
  always_comb begin
    stateNext = state;
    if (anyAcc) begin
      if (chRd) stateNext = K_CH;
      else begin
        unique case (state)
          K_CH:  stateNext = scRd ? K_CH : ((scWr && knockBit) ? K_SCW : K_IDLE);
          K_SCW: stateNext = scRd  ? K_SCR : K_IDLE;
          K_SCR: stateNext = altRd ? K_AS1 : K_IDLE;
          K_AS1: stateNext = altRd ? K_AS2 : K_IDLE;
          K_AS2: stateNext = scRd  ? K_SC3 : K_IDLE;
          default: stateNext = K_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= K_IDLE;
      openQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (chRd) openQ <= 1'b0;
      else if (HAS_UNLOCK && state == K_SC3 && scRd) openQ <= 1'b1;
    end
  end

  assign strobe.open   = openQ;
  assign strobe.timWr  = openQ && ioWr && cmdWin && (ioAddr == P_SNUM);
  assign strobe.commit = openQ && scWr && commitBit;
endmodule

// File: rtl/timing_regs.sv
`timescale 1ns/1ps
module timing_regs
  import knock_pkg::*;
#(
  parameter int         NUM_DRIVES = 2,
  parameter int         FIELD_W    = 3,
  parameter bit         HAS_UNLOCK = 1'b1,
  parameter logic [7:0] ALT_STATUS = 8'h50,
  localparam int TIM_W = NUM_DRIVES * FIELD_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [2:0]                   ioAddr,
  input  logic                         ctlSel,
  input  logic                         ioWr,
  input  logic [7:0]                   wrData,
  input  ctlStrobe_t                   strobe,
  output logic [7:0]                   rdData,
  output logic [TIM_W-1:0]             driveCode,
  output logic [NUM_DRIVES*MODE_W-1:0] driveMode
);
  localparam logic [FIELD_W-1:0] CODE_M1 = FIELD_W'(1 + 3 * 1);
  localparam logic [FIELD_W-1:0] CODE_M2 = FIELD_W'(1 + 3 * 2);

  logic [7:0] scReg, snReg, clReg, chReg;
  logic [TIM_W-1:0] pending, committed;
  logic cmdWr;
  assign cmdWr = ioWr && !ctlSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      scReg <= '0; snReg <= '0; clReg <= '0; chReg <= '0;
      pending <= '0; committed <= '0;
    end else begin
      if (cmdWr && ioAddr == P_SCNT) scReg <= wrData;
      if (cmdWr && ioAddr == P_SNUM && !strobe.open) snReg <= wrData;
      if (cmdWr && ioAddr == P_CLOW) clReg <= wrData;
      if (cmdWr && ioAddr == P_CHIGH) chReg <= wrData;
      if (strobe.timWr) pending <= wrData[TIM_W-1:0];
      if (strobe.commit) committed <= pending;
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (ctlSel) begin
      if (ioAddr == P_ALT) rdData = ALT_STATUS;
    end else begin
      unique case (ioAddr)
        P_SCNT:  rdData = HAS_UNLOCK ? {!strobe.open, scReg[6:0]} : 8'h00;
        P_SNUM:  rdData = strobe.open ? 8'(pending) : snReg;
        P_CLOW:  rdData = clReg;
        P_CHIGH: rdData = chReg;
        default: rdData = 8'h00;
      endcase
    end
  end

  assign driveCode = committed;

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_decode
    logic [FIELD_W-1:0] code;
    assign code = committed[d*FIELD_W +: FIELD_W];
    always_comb begin
      if (code == CODE_M2)      driveMode[d*MODE_W +: MODE_W] = 2'd2;
      else if (code == CODE_M1) driveMode[d*MODE_W +: MODE_W] = 2'd1;
      else                      driveMode[d*MODE_W +: MODE_W] = 2'd0;
    end
  end
endmodule

// File: rtl/knock_timing_unlock.sv
`timescale 1ns/1ps
module knock_timing_unlock
  import knock_pkg::*;
#(
  parameter int         NUM_DRIVES = 2,
  parameter int         FIELD_W    = 3,
  parameter bit         HAS_UNLOCK = 1'b1,
  parameter logic [7:0] ALT_STATUS = 8'h50
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [2:0]                            ioAddr,
  input  logic                                  ctlSel,
  input  logic                                  ioRd,
  input  logic                                  ioWr,
  input  logic [7:0]                            wrData,
  output logic [7:0]                            rdData,
  output logic [NUM_DRIVES*FIELD_W-1:0]         driveCode,
  output logic [NUM_DRIVES*knock_pkg::MODE_W-1:0] driveMode
);
  ctlStrobe_t strobe;
  logic lockOpen;
  assign lockOpen = strobe.open;

  knock_ctrl #(.HAS_UNLOCK(HAS_UNLOCK)) i_ctrl (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ctlSel(ctlSel),
    .ioRd(ioRd), .ioWr(ioWr), .knockBit(wrData[7]), .commitBit(wrData[0]),
    .strobe(strobe)
  );

  timing_regs #(
    .NUM_DRIVES(NUM_DRIVES), .FIELD_W(FIELD_W),
    .HAS_UNLOCK(HAS_UNLOCK), .ALT_STATUS(ALT_STATUS)
  ) i_regs (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ctlSel(ctlSel), .ioWr(ioWr),
    .wrData(wrData), .strobe(strobe), .rdData(rdData),
    .driveCode(driveCode), .driveMode(driveMode)
  );
endmodule

// File: rtl/knock_timing_chk.sv
`timescale 1ns/1ps
module knock_timing_chk #(
  parameter int NUM_DRIVES = 2,
  parameter int FIELD_W    = 3,
  parameter bit HAS_UNLOCK = 1'b1
) (
  input logic                          clk,
  input logic                          rst,
  input logic [2:0]                    ioAddr,
  input logic                          ctlSel,
  input logic                          ioRd,
  input logic                          ioWr,
  input logic [7:0]                    wrData,
  input logic [7:0]                    rdData,
  input logic [NUM_DRIVES*FIELD_W-1:0] driveCode,
  input logic [NUM_DRIVES*2-1:0]       driveMode,
  input logic                          lockOpen
);
  logic scWrCommit;
  assign scWrCommit = ioWr && !ctlSel && (ioAddr == 3'd2) && wrData[0];

  // R1: leaving reset the codes are cleared
  a_r1_reset_codes: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (driveCode == '0 && driveMode == '0));

  // R6: codes move only on a commit write
  a_r6_no_commit_hold: assert property (@(posedge clk) disable iff (rst)
    !scWrCommit |=> $stable(driveCode));

  // R6: nothing commits while locked
  a_r6_locked_hold: assert property (@(posedge clk) disable iff (rst)
    !lockOpen |=> $stable(driveCode));

  // R2: locked sector-count reads show the lock bit
  a_r2_locked_bit: assert property (@(posedge clk) disable iff (rst)
    (HAS_UNLOCK && ioRd && !ctlSel && ioAddr == 3'd2 && !lockOpen) |-> rdData[7]);

  // R7: cylinder-high read closes the window
  a_r7_relock: assert property (@(posedge clk) disable iff (rst)
    (ioRd && !ctlSel && ioAddr == 3'd5) |=> !lockOpen);

  // R8: modes change only with codes
  a_r8_mode_follows: assert property (@(posedge clk) disable iff (rst)
    $stable(driveCode) |-> $stable(driveMode));
endmodule

bind knock_timing_unlock knock_timing_chk #(
  .NUM_DRIVES(NUM_DRIVES), .FIELD_W(FIELD_W), .HAS_UNLOCK(HAS_UNLOCK)
) i_chk (
  .clk(clk), .rst(rst), .ioAddr(ioAddr), .ctlSel(ctlSel), .ioRd(ioRd),
  .ioWr(ioWr), .wrData(wrData), .rdData(rdData), .driveCode(driveCode),
  .driveMode(driveMode), .lockOpen(lockOpen)
);

// File: tb/test_knock_timing_unlock.sv
`timescale 1ns/1ps
module test_knock_timing_unlock;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] ioAddr = '0;
  logic ctlSel = 1'b0, ioRd = 1'b0, ioWr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, rdDataB;
  logic [5:0] driveCode, driveCodeB;
  logic [3:0] driveMode, driveModeB;
  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  knock_timing_unlock i_knock_timing_unlock (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ctlSel(ctlSel), .ioRd(ioRd),
    .ioWr(ioWr), .wrData(wrData), .rdData(rdData),
    .driveCode(driveCode), .driveMode(driveMode));

  knock_timing_unlock #(.HAS_UNLOCK(1'b0)) i_knock_timing_unlockB (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ctlSel(ctlSel), .ioRd(ioRd),
    .ioWr(ioWr), .wrData(wrData), .rdData(rdDataB),
    .driveCode(driveCodeB), .driveMode(driveModeB));

  typedef struct { logic [7:0] expv; bit chk; string tag; } rdItem_t;
  rdItem_t expQ[$];

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    if (ioRd && !rst) begin
      if (expQ.size() == 0) begin
        nTests++; nFail++;
        $display("FAIL monitor: read with empty queue, actual %h expected none", rdData);
      end else begin
        rdItem_t it;
        it = expQ.pop_front();
        if (it.chk) begin
          nTests++;
          if (rdData !== it.expv) begin
            nFail++;
            $display("FAIL %s: rdData actual %h expected %h", it.tag, rdData, it.expv);
          end
        end
      end
    end
  end

  task automatic busWr(input logic [2:0] a, input logic cs, input logic [7:0] d);
    @(posedge clk); #1;
    ioAddr = a; ctlSel = cs; wrData = d; ioWr = 1'b1;
    @(posedge clk); #1;
    ioWr = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a, input logic cs, input logic [7:0] e,
                       input bit chk, input string tag);
    rdItem_t it;
    @(posedge clk); #1;
    ioAddr = a; ctlSel = cs; ioRd = 1'b1;
    it.expv = e; it.chk = chk; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk); #1;
    ioRd = 1'b0;
  endtask

  task automatic readB(input logic [2:0] a, input logic [7:0] e, input string tag);
    rdItem_t it;
    @(posedge clk); #1;
    ioAddr = a; ctlSel = 1'b0; ioRd = 1'b1;
    it.expv = 8'h00; it.chk = 1'b0; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    nTests++;
    if (rdDataB !== e) begin
      nFail++;
      $display("FAIL %s: variant rdData actual %h expected %h", tag, rdDataB, e);
    end
    @(posedge clk); #1;
    ioRd = 1'b0;
  endtask

  task automatic checkCodes(input logic [5:0] ec, input logic [3:0] em, input string tag);
    @(negedge clk);
    nTests++;
    if (driveCode !== ec || driveMode !== em) begin
      nFail++;
      $display("FAIL %s: code/mode actual %h/%h expected %h/%h",
               tag, driveCode, driveMode, ec, em);
    end
  endtask

  task automatic knock(input logic [7:0] scVal);
    busRd(3'd5, 1'b0, 8'h00, 1'b0, "knock");
    busRd(3'd2, 1'b0, 8'h00, 1'b0, "knock");
    busWr(3'd2, 1'b0, scVal | 8'h80);
    busRd(3'd2, 1'b0, 8'h00, 1'b0, "knock");
    busRd(3'd6, 1'b1, 8'h00, 1'b0, "knock");
    busRd(3'd6, 1'b1, 8'h00, 1'b0, "knock");
    busRd(3'd2, 1'b0, 8'h00, 1'b0, "knock");
    busRd(3'd2, 1'b0, 8'h00, 1'b0, "knock");
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    checkCodes(6'h00, 4'h0, "R1 reset codes");
    busRd(3'd2, 1'b0, 8'h80, 1'b1, "R1 sector-count after reset");
    busRd(3'd3, 1'b0, 8'h00, 1'b1, "R1 sector-number after reset");
    // R3 plain registers while locked
    busWr(3'd4, 1'b0, 8'h3C);
    busRd(3'd4, 1'b0, 8'h3C, 1'b1, "R3 cylinder-low");
    busWr(3'd3, 1'b0, 8'h12);
    busRd(3'd3, 1'b0, 8'h12, 1'b1, "R3 sector-number");
    busWr(3'd2, 1'b0, 8'h05);
    busRd(3'd2, 1'b0, 8'h85, 1'b1, "R3 sector-count bit7 forced");
    busRd(3'd6, 1'b1, 8'h50, 1'b1, "R3 alt status");
    busRd(3'd7, 1'b0, 8'h00, 1'b1, "R3 unwatched offset");
    // R4 broken knock: out-of-order cylinder-low read
    busRd(3'd5, 1'b0, 8'h00, 1'b0, "brk");
    busWr(3'd2, 1'b0, 8'h85);
    busRd(3'd2, 1'b0, 8'h00, 1'b0, "brk");
    busRd(3'd6, 1'b1, 8'h00, 1'b0, "brk");
    busRd(3'd4, 1'b0, 8'h00, 1'b0, "brk");
    busRd(3'd6, 1'b1, 8'h00, 1'b0, "brk");
    busRd(3'd2, 1'b0, 8'h00, 1'b0, "brk");
    busRd(3'd2, 1'b0, 8'h00, 1'b0, "brk");
    busRd(3'd2, 1'b0, 8'h85, 1'b1, "R4 out-of-order stays locked");
    // R4 broken knock: bit 7 clear on the write
    busRd(3'd5, 1'b0, 8'h00, 1'b0, "brk");
    busWr(3'd2, 1'b0, 8'h05);
    busRd(3'd2, 1'b0, 8'h00, 1'b0, "brk");
    busRd(3'd6, 1'b1, 8'h00, 1'b0, "brk");
    busRd(3'd6, 1'b1, 8'h00, 1'b0, "brk");
    busRd(3'd2, 1'b0, 8'h00, 1'b0, "brk");
    busRd(3'd2, 1'b0, 8'h00, 1'b0, "brk");
    busRd(3'd2, 1'b0, 8'h85, 1'b1, "R4 missing bit7 stays locked");
    // R2 / R4 fresh full knock unlocks
    knock(8'h05);
    busRd(3'd2, 1'b0, 8'h05, 1'b1, "R2 unlocked bit7 clear");
    // R5 timing register window
    busRd(3'd3, 1'b0, 8'h00, 1'b1, "R5 pending reset value");
    busWr(3'd3, 1'b0, 8'h3C);
    busRd(3'd3, 1'b0, 8'h3C, 1'b1, "R5 pending readback");
    checkCodes(6'h00, 4'h0, "R6 no commit yet");
    busWr(3'd2, 1'b0, 8'h04);
    checkCodes(6'h00, 4'h0, "R6 bit0 clear no commit");
    busWr(3'd2, 1'b0, 8'h05);
    checkCodes(6'h3C, 4'b1001, "R6 R8 commit modes 1 and 2");
    busWr(3'd3, 1'b0, 8'h0A);
    busWr(3'd2, 1'b0, 8'h01);
    checkCodes(6'h0A, 4'b0000, "R8 illegal codes decode to 0");
    busWr(3'd3, 1'b0, 8'h20);
    busWr(3'd2, 1'b0, 8'h01);
    checkCodes(6'h20, 4'b0100, "R5 drive1 field bits 5:3");
    // R7 relock
    busRd(3'd5, 1'b0, 8'h00, 1'b1, "R7 cylinder-high read");
    busRd(3'd2, 1'b0, 8'h81, 1'b1, "R7 bit7 set again");
    busRd(3'd3, 1'b0, 8'h12, 1'b1, "R7 sector-number untouched");
    // R6 locked commit ignored
    busWr(3'd2, 1'b0, 8'h01);
    busWr(3'd3, 1'b0, 8'h3F);
    checkCodes(6'h20, 4'b0100, "R6 locked writes ignored");
    busRd(3'd3, 1'b0, 8'h3F, 1'b1, "R6 locked offset3 plain");
    // R9 non-unlocking variant
    busWr(3'd2, 1'b0, 8'h55);
    readB(3'd2, 8'h00, "R9 readback 1");
    readB(3'd2, 8'h00, "R9 readback 2");
    readB(3'd2, 8'h00, "R9 readback 3");
    busRd(3'd2, 1'b0, 8'hD5, 1'b1, "R3 locked 0x55 readback");
    knock(8'h55);
    busWr(3'd3, 1'b0, 8'h07);
    busWr(3'd2, 1'b0, 8'h01);
    checkCodes(6'h07, 4'b0010, "R2 second knock commits");
    @(negedge clk);
    nTests++;
    if (driveCodeB !== 6'h00 || driveModeB !== 4'h0) begin
      nFail++;
      $display("FAIL R9: variant code actual %h expected 00", driveCodeB);
    end
    readB(3'd2, 8'h00, "R9 after knock");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule